// File: doc/BRIEF.md
# Batched Union-Find Equivalence Merger

This block keeps a forest of label equivalences in a parent-pointer memory with one entry per label. The entry holds that label's parent. A producer upstream, such as a labeling pass that finds touching regions, hands in batches of up to four equivalence pairs. For each pair the block loads the parent of the pair's smaller label. It finds which pairs of the batch are tied together through shared labels. Every pair in a tied group receives the smallest loaded parent of that group, and that value is written back to both labels of each pair.

Batches enter on a valid/ready stream. A batch is captured only on a cycle where `in_valid` and `in_ready` are both high. While `in_ready` is low, the producer must hold the batch stable. `in_ready` is low while the memory is being cleared and while the pipeline is busy. When the producer keeps `in_valid` high, one batch is accepted every eight cycles, because the store stage writes one address per cycle. A later batch always sees the results of earlier batches, even when those results have not yet reached the memory.

The memory is reset to the identity mapping after reset and after each `frame_start` pulse. A registered read port with one cycle of latency lets later stages look up parents.

Top module: `ufm_merger`

## Requirements
- R1: After reset is released, and after each `frame_start` pulse, the block writes parent[x] = x for every label x, one address per cycle. `in_ready` stays low for exactly 2^LBL_W cycles, then rises.
- R2: For pair i, the loaded parent is the parent of min(a_i, b_i). Pair i's labels are field i of `in_lab_a` and `in_lab_b`: bits [LBL_W*i +: LBL_W].
- R3: Two valid pairs are tied when they share any label, and ties are followed transitively. Every valid pair gets the minimum loaded parent over its tied group. That result is written to both of the pair's labels. Every stored parent therefore stays less than or equal to its own label.
- R4: A pair whose bit in `in_mask` is 0 (bit i for pair i) writes nothing. It also ties no other pairs together.
- R5: A batch is taken only on a cycle with `in_valid` and `in_ready` both high. After an accept, `in_ready` is low the next cycle. Accepts are at least eight cycles apart. With `in_valid` held high, they come exactly eight cycles apart. A batch offered while `in_ready` is low has no effect.
- R6: A batch loads parents as if every earlier batch had finished its writes. This holds when the next batch is accepted back to back and an earlier write is still pending.
- R7: `rd_data` returns parent[`rd_addr`] one cycle after the address is presented.
- R8: `frame_start` drops every batch in flight and starts the clear of R1. `in_ready` is low on the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Pulse: abort the work in flight and clear the forest |
| in_valid | input | 1 | A batch is offered |
| in_ready | output | 1 | The block can take a batch this cycle |
| in_mask | input | 4 | Per-pair valid bits; bit i belongs to pair i |
| in_lab_a | input | 4*LBL_W | First label of each pair; field i is pair i |
| in_lab_b | input | 4*LBL_W | Second label of each pair; field i is pair i |
| rd_addr | input | LBL_W | Lookup address |
| rd_data | output | LBL_W | Parent of the label addressed on the previous cycle |

## Verification
Take the accept edge of a batch as edge 0. Its parents are captured at edge 1 and its group results at edge 2. The labels of pair i are written at edges 3+2i and 4+2i, so a read issued after edge 10 sees all of them. The bench holds `in_valid` high so that batches follow each other at the eight-cycle spacing. One batch loads a label that the previous batch writes only at edge 10, which exercises the pending-write path. The bench compares readback values with its own model only after those writes are due. It counts clear lengths in cycles from the last reset or `frame_start` edge, and it samples everything at the falling edge.

// File: rtl/ufm_pkg.sv
package ufm_pkg;
  localparam int NPAIR     = 4;
  localparam int STORE_CYC = 2 * NPAIR;
  localparam int STC_W     = $clog2(STORE_CYC);
  localparam int READY_AT  = STORE_CYC - 3;
  typedef logic [NPAIR-1:0] pmask_t;
endpackage

// File: rtl/ufm_parent_ram.sv
module ufm_parent_ram
  import ufm_pkg::*;
#(
  parameter int LW = 6
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [LW-1:0]            waddr,
  input  logic [LW-1:0]            wdata,
  input  logic [NPAIR-1:0][LW-1:0] lk_addr,
  output logic [NPAIR-1:0][LW-1:0] lk_data,
  input  logic [LW-1:0]            rd_addr,
  output logic [LW-1:0]            rd_data
);
  localparam int DEPTH = 1 << LW;

  logic [LW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_data <= mem[rd_addr];
  end

  for (genvar i = 0; i < NPAIR; i++) begin : g_lookup
    assign lk_data[i] = mem[lk_addr[i]];
  end
endmodule

// File: rtl/ufm_group_min.sv
module ufm_group_min
  import ufm_pkg::*;
#(
  parameter int LW = 6
) (
  input  logic [NPAIR-1:0][LW-1:0] lab_a,
  input  logic [NPAIR-1:0][LW-1:0] lab_b,
  input  pmask_t                   mask,
  input  logic [NPAIR-1:0][LW-1:0] par,
  output logic [NPAIR-1:0][LW-1:0] res
);
  logic [NPAIR-1:0][NPAIR-1:0] reach;

  // direct ties, then transitive closure over the batch
  always_comb begin
    for (int i = 0; i < NPAIR; i++) begin
      for (int j = 0; j < NPAIR; j++) begin
        reach[i][j] = mask[i] && mask[j] &&
                      ((i == j) ||
                       lab_a[i] == lab_a[j] || lab_a[i] == lab_b[j] ||
                       lab_b[i] == lab_a[j] || lab_b[i] == lab_b[j]);
      end
    end
    for (int k = 0; k < NPAIR; k++) begin
      for (int i = 0; i < NPAIR; i++) begin
        for (int j = 0; j < NPAIR; j++) begin
          if (reach[i][k] && reach[k][j]) reach[i][j] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NPAIR; i++) begin
      res[i] = par[i];
      for (int j = 0; j < NPAIR; j++) begin
        if (reach[i][j] && par[j] < res[i]) res[i] = par[j];
      end
    end
  end
endmodule

// File: rtl/ufm_merger.sv
module ufm_merger
  import ufm_pkg::*;
#(
  parameter int LBL_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_start,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NPAIR-1:0]       in_mask,
  input  logic [NPAIR*LBL_W-1:0] in_lab_a,
  input  logic [NPAIR*LBL_W-1:0] in_lab_b,
  input  logic [LBL_W-1:0]       rd_addr,
  output logic [LBL_W-1:0]       rd_data
);
  typedef logic [NPAIR-1:0][LBL_W-1:0] lvec_t;

  // clear sequencer
  logic             clr;
  logic [LBL_W-1:0] clr_addr;

  // stage 1: accepted pairs; stage 2: loaded parents; stage 3: store
  logic             v1, v2, v3;
  lvec_t            a1, b1, a2, b2, a3, b3;
  pmask_t           m1, m2, m3;
  lvec_t            p2, r3;
  logic [STC_W-1:0] st_cnt;

  lvec_t            lk_addr, lk_data, par_ld, grp_res;
  logic             mem_we;
  logic [LBL_W-1:0] mem_waddr, mem_wdata;

  logic             accept;
  logic [STC_W-2:0] st_pair;
  logic             st_side;

  assign in_ready = !clr && !v1 && !v2 && (!v3 || st_cnt >= STC_W'(READY_AT));
  assign accept   = in_valid && in_ready;

  // load index is the smaller label of each pair; forward pending stores
  for (genvar i = 0; i < NPAIR; i++) begin : g_load
    assign lk_addr[i] = (a1[i] < b1[i]) ? a1[i] : b1[i];
    always_comb begin
      par_ld[i] = lk_data[i];
      for (int j = 0; j < NPAIR; j++) begin
        if (v3 && m3[j] && (a3[j] == lk_addr[i] || b3[j] == lk_addr[i]))
          par_ld[i] = r3[j];
      end
    end
  end

  ufm_group_min #(.LW(LBL_W)) u_group (
    .lab_a (a2),
    .lab_b (b2),
    .mask  (m2),
    .par   (p2),
    .res   (grp_res)
  );

  assign st_pair = st_cnt[STC_W-1:1];
  assign st_side = st_cnt[0];

  always_comb begin
    if (clr) begin
      mem_we    = 1'b1;
      mem_waddr = clr_addr;
      mem_wdata = clr_addr;
    end else begin
      mem_we    = v3 && m3[st_pair];
      mem_waddr = st_side ? b3[st_pair] : a3[st_pair];
      mem_wdata = r3[st_pair];
    end
  end

  ufm_parent_ram #(.LW(LBL_W)) u_ram (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .lk_addr (lk_addr),
    .lk_data (lk_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr      <= 1'b1;
      clr_addr <= '0;
    end else if (frame_start) begin
      clr      <= 1'b1;
      clr_addr <= '0;
    end else if (clr) begin
      clr_addr <= clr_addr + 1'b1;
      if (&clr_addr) clr <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      st_cnt <= '0;
    end else if (frame_start) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      st_cnt <= '0;
    end else begin
      v1 <= accept;
      v2 <= v1;
      if (v2) begin
        v3     <= 1'b1;
        st_cnt <= '0;
      end else if (v3) begin
        st_cnt <= st_cnt + 1'b1;
        if (st_cnt == STC_W'(STORE_CYC - 1)) v3 <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      a1 <= in_lab_a;
      b1 <= in_lab_b;
      m1 <= in_mask;
    end
    if (v1) begin
      a2 <= a1; b2 <= b1; m2 <= m1; p2 <= par_ld;
    end
    if (v2) begin
      a3 <= a2; b3 <= b2; m3 <= m2; r3 <= grp_res;
    end
  end
endmodule

// File: rtl/ufm_merger_chk.sv
module ufm_merger_chk
  import ufm_pkg::*;
#(
  parameter int LBL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             in_valid,
  input logic             in_ready,
  input logic             v2,
  input logic             v3,
  input logic [STC_W-1:0] st_cnt,
  input logic             clr,
  input logic             mem_we,
  input logic [LBL_W-1:0] mem_waddr,
  input logic [LBL_W-1:0] mem_wdata
);
  logic [3:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= 4'd15;
    else if (in_valid && in_ready) gap <= 4'd1;
    else if (gap != 4'd15) gap <= gap + 4'd1;
  end

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !in_ready);

  p_busy_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_accept_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> gap >= 4'(STORE_CYC));

  p_union_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    v2 |-> (!v3 || st_cnt == STC_W'(STORE_CYC - 1)));

  p_parent_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !clr) |-> mem_wdata <= mem_waddr);
endmodule

bind ufm_merger ufm_merger_chk #(.LBL_W(LBL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .v2          (v2),
  .v3          (v3),
  .st_cnt      (st_cnt),
  .clr         (clr),
  .mem_we      (mem_we),
  .mem_waddr   (mem_waddr),
  .mem_wdata   (mem_wdata)
);

// File: tb/ufm_merger_bench.sv
module ufm_merger_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LW    = 6;
  localparam int DEPTH = 1 << LW;
  localparam int NROW  = 9;

  typedef struct packed {
    logic [4*LW-1:0] a;
    logic [4*LW-1:0] b;
    logic [3:0]      m;
    logic [4*LW-1:0] r;
  } row_t;

  function automatic logic [4*LW-1:0] pk(int l0, int l1, int l2, int l3);
    return {l3[LW-1:0], l2[LW-1:0], l1[LW-1:0], l0[LW-1:0]};
  endfunction

  // stimulus and expected group results, pair 0 in the low field
  localparam row_t TBL [NROW] = '{
    '{pk(4,2,3,20),     pk(5,7,6,21),     4'b0111, pk(4,2,3,0)},
    '{pk(1,30,32,34),   pk(4,31,33,35),   4'b0001, pk(1,0,0,0)},
    '{pk(4,7,6,5),      pk(6,8,10,10),    4'b1111, pk(1,2,1,1)},
    '{pk(50,52,3,11),   pk(51,53,11,12),  4'b1100, pk(0,0,3,3)},
    '{pk(12,16,54,56),  pk(15,17,55,57),  4'b0011, pk(3,16,0,0)},
    '{pk(20,21,22,23),  pk(21,22,23,24),  4'b1111, pk(20,20,20,20)},
    '{pk(25,26,30,28),  pk(30,27,8,29),   4'b1111, pk(2,26,2,28)},
    '{pk(7,58,60,62),   pk(8,59,61,63),   4'b0001, pk(2,0,0,0)},
    '{pk(40,41,44,46),  pk(41,44,45,47),  4'b0101, pk(40,0,44,0)}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            frame_start = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [3:0]      in_mask = '0;
  logic [4*LW-1:0] in_lab_a = '0;
  logic [4*LW-1:0] in_lab_b = '0;
  logic [LW-1:0]   rd_addr = '0;
  logic [LW-1:0]   rd_data;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int mdl [DEPTH];

  ufm_merger #(.LBL_W(LW)) u_ufm_merger (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_mask     (in_mask),
    .in_lab_a    (in_lab_a),
    .in_lab_b    (in_lab_b),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output int d);
    rd_addr = a[LW-1:0];
    @(negedge clk);
    d = int'(rd_data);
  endtask

  // counts cycles until in_ready rises, from the current negedge
  task automatic wait_ready(output int n);
    n = 0;
    while (!in_ready && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic send(input logic [4*LW-1:0] a, input logic [4*LW-1:0] b,
                      input logic [3:0] m, output int acc_cyc);
    in_lab_a = a; in_lab_b = b; in_mask = m; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    acc_cyc = cyc;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    int n, d, prev, acc;
    for (int i = 0; i < DEPTH; i++) mdl[i] = i;

    // reset and first clear; a batch offered during clear is ignored
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", int'(in_ready), 0);
    in_lab_a = pk(9,0,0,0); in_lab_b = pk(2,0,0,0); in_mask = 4'b0001;
    in_valid = 1'b1;
    rst_n = 1'b1;
    n = 0;
    repeat (10) begin @(negedge clk); n++; end
    chk("R5 ready low while busy", int'(in_ready), 0);
    in_valid = 1'b0;
    while (!in_ready && n < 1000) begin @(negedge clk); n++; end
    chk("R1 clear length", n, DEPTH);
    rd(0, d);  chk("R1 identity p0", d, 0);
    rd(63, d); chk("R1 identity p63", d, 63);
    rd(9, d);  chk("R5 offer during clear ignored p9", d, 9);

    // stream the table back to back
    prev = 0;
    for (int r = 0; r < NROW; r++) begin
      send(TBL[r].a, TBL[r].b, TBL[r].m, acc);
      if (r > 0) chk("R5 accept spacing", acc - prev, 8);
      prev = acc;
      for (int p = 0; p < 4; p++) begin
        if (TBL[r].m[p]) begin
          mdl[int'(TBL[r].a[p*LW +: LW])] = int'(TBL[r].r[p*LW +: LW]);
          mdl[int'(TBL[r].b[p*LW +: LW])] = int'(TBL[r].r[p*LW +: LW]);
        end
      end
    end
    repeat (16) @(negedge clk);

    rd(4, d);  chk("R3 example group p4", d, 1);
    rd(8, d);  chk("R2 example loose pair p8", d, 2);
    rd(12, d); chk("R6 pending write forwarded p12", d, 3);
    rd(15, d); chk("R6 pending write forwarded p15", d, 3);
    rd(45, d); chk("R4 masked pair no tie p45", d, 44);
    rd(21, d); chk("R4 masked pair no write p21", d, 20);
    rd(50, d); chk("R4 masked pair no write p50", d, 50);
    for (int i = 0; i < DEPTH; i++) begin
      rd(i, d);
      chk("R3 R7 forest readback", d, mdl[i]);
    end

    // abort in flight, then clear again
    send(pk(0,0,0,0), pk(33,0,0,0), 4'b0001, acc);
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    chk("R8 ready low after frame start", int'(in_ready), 0);
    wait_ready(n);
    chk("R1 clear length after frame start", n, DEPTH);
    rd(33, d); chk("R8 aborted batch p33", d, 33);
    rd(12, d); chk("R1 cleared p12", d, 12);
    rd(25, d); chk("R1 cleared p25", d, 25);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule